// File: doc/BRIEF.md
# Boot-Remap Chip Select and Wait-State Controller

This block sits between a 16-bit processor bus and the devices behind it. On every clock edge with the address strobe high it looks at the address, the upper and lower data strobes and the three function-code bits. It then drives one of four device selects: a ROM, a byte-split RAM, a serial controller or a peripheral window. It also drives a data-acknowledge back to the processor, either at once or after a fixed wait. All outputs are registered, so each one shows the inputs sampled at the most recent rising clock edge.

After reset, the first four strobed bus cycles select the ROM whatever their address. This lets the processor's reset vectors, fetched from the bottom of the address space, come out of the ROM at the top half. From the fifth strobed cycle on, the selects follow the address alone. During an interrupt-acknowledge cycle the serial controller select is held off and an autovector request is raised in its place.

Top module: `bus_sel_ctrl`

## Requirements
- R1: With the strobe high and no boot override, A15:A14 = 2'b10 asserts `rom_sel` and gives `dtack` on the same edge, with no wait.
- R2: A15:A14 = 2'b00 selects RAM. `ram_sel_hi` follows `uds` and `ram_sel_lo` follows `lds`. A13:A12 have no effect on the select. The acknowledge is immediate.
- R3: A15:A13 = 3'b111, outside an interrupt acknowledge, asserts `ser_sel` and puts A4:A1 on `ser_reg`. A12:A5 are ignored. `ser_reg` reads 0 whenever `ser_sel` is low.
- R4: A15:A13 = 3'b110 asserts `per_sel`.
- R5: The first four strobed cycles after reset (a cycle starts on a low-to-high change of `as`) assert `rom_sel` only, whatever the address, and acknowledge at once.
- R6: From the fifth strobed cycle on, the address alone chooses the select.
- R7: Outside the boot override, a cycle with A15:A14 = 2'b11 keeps `dtack` low after the first and second edges with `as` high, and raises it after the third.
- R8: Function code 3'b111 with the strobe high asserts `vpa` and keeps `ser_sel` low.
- R9: A15:A14 = 2'b01 asserts no select but still acknowledges at once.
- R10: At the first edge with `as` low, every select, `vpa` and `dtack` go to 0. The wait count restarts in the next cycle.
- R11: While `rst` is high, all outputs are 0 and the boot override is re-armed.
- R12: At most one of ROM, RAM (either byte), serial and peripheral is selected at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address |
| as | input | 1 | Address strobe, active high |
| uds | input | 1 | Upper data strobe, active high |
| lds | input | 1 | Lower data strobe, active high |
| fc | input | 3 | Processor function code |
| rom_sel | output | 1 | ROM select |
| ram_sel_hi | output | 1 | RAM upper byte select |
| ram_sel_lo | output | 1 | RAM lower byte select |
| ser_sel | output | 1 | Serial controller select |
| ser_reg | output | 4 | Serial register index (A4:A1) |
| per_sel | output | 1 | Peripheral window select |
| vpa | output | 1 | Autovector request |
| dtack | output | 1 | Data acknowledge |

## Verification
The properties assume the processor keeps the address and function code steady while `as` stays high. They also assume every bus cycle ends with at least one edge where `as` is low, because the boot count and the wait check both look for the rising strobe. The bench drives inputs only on falling clock edges. It holds each cycle's address for the whole strobe and drops `as` for one edge between cycles. This way every cycle starts with a fresh rise that the boot counter and the wait timer see.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    Q_RAM = 2'b00,
    Q_GAP = 2'b01,
    Q_ROM = 2'b10,
    Q_TOP = 2'b11
  } quad_e;

  typedef struct packed {
    logic       rom;
    logic       ram_hi;
    logic       ram_lo;
    logic       ser;
    logic [3:0] ser_reg;
    logic       per;
    logic       vpa;
    logic       fast;
  } sel_t;
endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
  import bsc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int FC_W = 3
) (
  input  logic [AW-1:0]   addr,
  input  logic            as,
  input  logic            uds,
  input  logic            lds,
  input  logic [FC_W-1:0] fc,
  input  logic            boot,
  output sel_t            sel
);
  localparam logic [FC_W-1:0] FC_IACK = '1;

  quad_e quad;
  logic  upper_half;
  logic  iack;
  logic  norm;

  always_comb begin
    quad       = quad_e'(addr[AW-1 -: 2]);
    upper_half = addr[AW-3];
    iack       = as && (fc == FC_IACK);
    norm       = as && !boot;
    sel        = '0;
    sel.vpa    = iack;
    sel.rom    = as && (boot || quad == Q_ROM);
    sel.ram_hi = norm && quad == Q_RAM && uds;
    sel.ram_lo = norm && quad == Q_RAM && lds;
    sel.ser    = norm && quad == Q_TOP && upper_half && !iack;
    sel.per    = norm && quad == Q_TOP && !upper_half;
    sel.fast   = boot || quad != Q_TOP;
    if (sel.ser)
      sel.ser_reg = addr[4:1];
  end
endmodule

// File: rtl/bsc_boot.sv
module bsc_boot #(
  parameter int BOOT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic as,
  output logic boot
);
  localparam int CW = $clog2(BOOT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BOOT_CYCLES);

  logic          as_q;
  logic          boot_q;
  logic [CW-1:0] cnt;
  logic          rise;
  logic          armed;

  always_comb begin
    rise  = as && !as_q;
    armed = cnt < LIMIT;
    boot  = as && (rise ? armed : boot_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q   <= 1'b0;
      boot_q <= 1'b0;
      cnt    <= '0;
    end else begin
      as_q <= as;
      if (rise) begin
        boot_q <= armed;
        if (armed)
          cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsc_wait.sv
module bsc_wait #(
  parameter int WAIT_EDGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic as,
  input  logic fast,
  output logic ack
);
  localparam int WW = $clog2(WAIT_EDGES + 1);
  localparam logic [WW-1:0] LAST = WW'(WAIT_EDGES - 1);

  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !as) begin
      cnt <= '0;
      ack <= 1'b0;
    end else if (fast) begin
      cnt <= '0;
      ack <= 1'b1;
    end else begin
      if (cnt < LAST)
        cnt <= cnt + 1'b1;
      ack <= (cnt >= LAST);
    end
  end
endmodule

// File: rtl/bus_sel_ctrl.sv
module bus_sel_ctrl
  import bsc_pkg::*;
#(
  parameter int AW          = 16,
  parameter int FC_W        = 3,
  parameter int BOOT_CYCLES = 4,
  parameter int WAIT_EDGES  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            as,
  input  logic            uds,
  input  logic            lds,
  input  logic [FC_W-1:0] fc,
  output logic            rom_sel,
  output logic            ram_sel_hi,
  output logic            ram_sel_lo,
  output logic            ser_sel,
  output logic [3:0]      ser_reg,
  output logic            per_sel,
  output logic            vpa,
  output logic            dtack
);
  logic boot_now;
  sel_t sel_d;
  sel_t sel_q;

  bsc_boot #(.BOOT_CYCLES(BOOT_CYCLES)) u_boot (
    .clk(clk), .rst(rst), .as(as), .boot(boot_now)
  );

  bsc_decode #(.AW(AW), .FC_W(FC_W)) u_dec (
    .addr(addr), .as(as), .uds(uds), .lds(lds), .fc(fc),
    .boot(boot_now), .sel(sel_d)
  );

  bsc_wait #(.WAIT_EDGES(WAIT_EDGES)) u_wait (
    .clk(clk), .rst(rst), .as(as), .fast(sel_d.fast), .ack(dtack)
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end

  assign rom_sel    = sel_q.rom;
  assign ram_sel_hi = sel_q.ram_hi;
  assign ram_sel_lo = sel_q.ram_lo;
  assign ser_sel    = sel_q.ser;
  assign ser_reg    = sel_q.ser_reg;
  assign per_sel    = sel_q.per;
  assign vpa        = sel_q.vpa;
endmodule

// File: rtl/bus_sel_ctrl_chk.sv
module bus_sel_ctrl_chk #(
  parameter int AW   = 16,
  parameter int FC_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   addr,
  input logic            as,
  input logic [FC_W-1:0] fc,
  input logic            boot_now,
  input logic            rom_sel,
  input logic            ram_sel_hi,
  input logic            ram_sel_lo,
  input logic            ser_sel,
  input logic            per_sel,
  input logic            vpa,
  input logic            dtack
);
  a_r12_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, ram_sel_hi | ram_sel_lo, ser_sel, per_sel}));

  a_r10_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !as |=> !dtack && !rom_sel && !ram_sel_hi && !ram_sel_lo && !ser_sel && !per_sel && !vpa);

  a_r8_iack_blocks_serial: assert property (@(posedge clk) disable iff (rst)
    as && fc == '1 |=> vpa && !ser_sel);

  a_r5_boot_forces_rom: assert property (@(posedge clk) disable iff (rst)
    as && boot_now |=> rom_sel && dtack);

  a_r7_no_early_ack: assert property (@(posedge clk) disable iff (rst)
    as && !$past(as) && addr[AW-1 -: 2] == 2'b11 && !boot_now |=> !dtack);

  a_r9_gap_acks: assert property (@(posedge clk) disable iff (rst)
    as && !boot_now && addr[AW-1 -: 2] == 2'b01 |=> dtack && !rom_sel && !ser_sel && !per_sel);
endmodule

bind bus_sel_ctrl bus_sel_ctrl_chk #(.AW(AW), .FC_W(FC_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .as(as), .fc(fc), .boot_now(boot_now),
  .rom_sel(rom_sel), .ram_sel_hi(ram_sel_hi), .ram_sel_lo(ram_sel_lo),
  .ser_sel(ser_sel), .per_sel(per_sel), .vpa(vpa), .dtack(dtack)
);

// File: tb/sim_bus_sel_ctrl.sv
module sim_bus_sel_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        as = 1'b0, uds = 1'b0, lds = 1'b0;
  logic [2:0]  fc = 3'b000;
  logic        rom_sel, ram_sel_hi, ram_sel_lo, ser_sel, per_sel, vpa, dtack;
  logic [3:0]  ser_reg;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sel_ctrl u0 (
    .clk(clk), .rst(rst), .addr(addr), .as(as), .uds(uds), .lds(lds), .fc(fc),
    .rom_sel(rom_sel), .ram_sel_hi(ram_sel_hi), .ram_sel_lo(ram_sel_lo),
    .ser_sel(ser_sel), .ser_reg(ser_reg), .per_sel(per_sel), .vpa(vpa), .dtack(dtack)
  );

  // packed observation: rom, ram_hi, ram_lo, ser, per, vpa, ser_reg[3:0]
  function automatic logic [9:0] obs();
    return {rom_sel, ram_sel_hi, ram_sel_lo, ser_sel, per_sel, vpa, ser_reg};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one bus cycle; slow means the acknowledge comes after the third edge
  task automatic bus_cycle(input string req, input logic [15:0] a, input logic [2:0] f,
                           input logic u, input logic l, input logic [9:0] exp_sel,
                           input bit slow);
    int edges;
    edges = slow ? 3 : 1;
    addr = a; fc = f; uds = u; lds = l; as = 1'b1;
    for (int e = 1; e <= edges; e++) begin
      edge_wait();
      check(req, obs(), exp_sel);
      check({req, " ack"}, {9'b0, dtack}, {9'b0, (e == edges)});
    end
    as = 1'b0; uds = 1'b0; lds = 1'b0; fc = 3'b000;
    edge_wait();
    check("R10 idle", {obs(), dtack}, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) edge_wait();
    check("R11 reset", {obs(), dtack}, '0);
    rst = 1'b0;
    edge_wait();
  endtask

  task automatic t_boot();
    bus_cycle("R5 boot 1", 16'h0000, 3'b110, 1, 1, 10'b1000000000, 0);
    bus_cycle("R5 boot 2", 16'h0002, 3'b110, 1, 1, 10'b1000000000, 0);
    bus_cycle("R5 boot 3", 16'h0004, 3'b110, 1, 1, 10'b1000000000, 0);
    bus_cycle("R5 boot 4 top", 16'hE006, 3'b101, 1, 1, 10'b1000000000, 0);
    bus_cycle("R6 after boot", 16'h0000, 3'b101, 1, 0, 10'b0100000000, 0);
  endtask

  task automatic t_memory();
    bus_cycle("R1 rom", 16'h8004, 3'b110, 1, 1, 10'b1000000000, 0);
    bus_cycle("R1 rom top", 16'hBFFE, 3'b110, 0, 1, 10'b1000000000, 0);
    bus_cycle("R2 ram lo", 16'h0102, 3'b101, 0, 1, 10'b0010000000, 0);
    bus_cycle("R2 ram both a13", 16'h3102, 3'b101, 1, 1, 10'b0110000000, 0);
    bus_cycle("R9 gap", 16'h5000, 3'b101, 1, 1, 10'b0000000000, 0);
  endtask

  task automatic t_slow();
    bus_cycle("R3 serial", 16'hE01A, 3'b101, 1, 1, 10'b0001001101, 1);
    bus_cycle("R3 serial ignores a12", 16'hFFE4, 3'b101, 1, 1, 10'b0001000010, 1);
    bus_cycle("R4 periph", 16'hC030, 3'b101, 1, 1, 10'b0000100000, 1);
    bus_cycle("R8 iack", 16'hFFF6, 3'b111, 1, 1, 10'b0000010000, 1);
  endtask

  task automatic t_rearm();
    t_reset();
    bus_cycle("R11 rearm boot", 16'h0000, 3'b110, 1, 1, 10'b1000000000, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_boot();
        t_memory();
        t_slow();
        t_rearm();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule